// File: doc/BRIEF.md
# I/O Slave FIFO Bookkeeping Unit

This block keeps the bookkeeping for an outbound byte FIFO that an I/O slave serves out of a local byte RAM. It holds the read pointer, the number of bytes waiting, a wider virtual byte counter and two interrupt banks. The serial side reports each byte it takes with a pop strobe. The host side pushes bytes, adds to the virtual counter and overwrites the pointer or the count with simple write strobes.

The local RAM is divided into regions on 8-byte segment boundaries. A combinational classifier tells, for any RAM address, whether it lies in the read-only window, the FIFO window or general RAM, or in none of them. The main interrupt bank has ten status bits with per-bit enable, write-1-set and write-1-clear controls. A second eight-bit I/O interrupt field is set bit by bit and cleared as a whole. One output line reports any enabled pending bit.

Top module: `ios_fifo_tracker`

## Requirements
- R1: After reset the pointer, byte count, virtual counter, both status banks, both enable masks and `irq_out` are 0. The read-only segment base resets to 0x20, and the FIFO base and limit reset to 0.
- R2: With lo = fifo_base*8, hi = fifo_max*8 and ro = ro_base*8, `ram_region` is 2 (FIFO) for lo <= addr < hi, 1 (read-only) for ro <= addr < lo, 3 (RAM) for addr >= hi, and 0 (none) otherwise. The FIFO test is applied first.
- R3: When fifo_max is 0x1F, an address at or above hi is classified 0 (none) instead of 3.
- R4: A pop while the count is nonzero advances the pointer by one, except that a pointer equal to hi-1 goes to lo. The count drops by one.
- R5: A pop while the count is 0 sets status bit 2 (underflow) and changes neither the pointer nor the count nor the virtual counter.
- R6: A push raises the count by one when count < hi-lo (0 if hi <= lo). Otherwise it sets status bit 1 (overflow) and the count is unchanged. A push and a pop in the same cycle each apply on their own terms.
- R7: Status bit 0 (size) is set in the cycle in which the count goes from above the threshold to at or below it.
- R8: The 10-bit virtual counter adds each increment write and subtracts each accepted pop, modulo 1024. Both apply in the same cycle when they coincide.
- R9: A status bit is set by its event input or by a 1 on `irq_set`, and is cleared by a 1 on `irq_clr`. If a set and a clear hit the same bit together, the set wins. The bits are: 0 size, 1 overflow, 2 underflow, 3 read error, 4 IO write, 5 general address, 6 read-FIFO done, 7 read-register done, 8 write-FIFO done, 9 write-register done.
- R10: `irq_out` is 1 exactly when some status bit and its enable are both 1, or some I/O interrupt bit and its enable are both 1.
- R11: Each 1 on `io_set` sets the matching I/O interrupt bit. `io_clr_all` clears all eight bits unless the same bit is being set in that cycle. The enable mask reads back on `io_irq_en`.
- R12: A host pointer or count write takes precedence over a pop or push in the same cycle, but the underflow and overflow events are still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the three segment bases |
| cfg_fifo_base | input | 5 | FIFO start segment |
| cfg_fifo_max | input | 6 | FIFO end segment, start of RAM |
| cfg_ro_base | input | 6 | Read-only window start segment |
| thr_we | input | 1 | Load threshold |
| thr_wdata | input | 8 | Size interrupt threshold |
| ptr_we | input | 1 | Host pointer write |
| ptr_wdata | input | 8 | New pointer value |
| cnt_we | input | 1 | Host count write |
| cnt_wdata | input | 8 | New byte count |
| push_vld | input | 1 | Host adds one byte |
| pop_vld | input | 1 | Serial side takes one byte |
| vinc_we | input | 1 | Virtual counter increment write |
| vinc_value | input | 10 | Increment amount |
| ext_evt | input | 10 | Event strobes into the status bank |
| irq_set | input | 10 | Write-1-set for status |
| irq_clr | input | 10 | Write-1-clear for status |
| irq_en_we | input | 1 | Load status enable mask |
| irq_en_wdata | input | 10 | Status enable mask |
| io_set | input | 8 | Write-1-set for I/O interrupts |
| io_clr_all | input | 1 | Clear all I/O interrupts |
| io_en_we | input | 1 | Load I/O enable mask |
| io_en_wdata | input | 8 | I/O enable mask |
| ram_addr | input | 9 | Address to classify |
| rd_ptr | output | 8 | Current FIFO pointer |
| byte_cnt | output | 8 | Bytes in the FIFO |
| vcnt | output | 10 | Virtual byte counter |
| irq_status | output | 10 | Status bank |
| irq_enable | output | 10 | Status enable mask |
| io_irq | output | 8 | I/O interrupt field |
| io_irq_en | output | 8 | I/O enable mask |
| irq_out | output | 1 | Combined interrupt |
| ram_region | output | 2 | 0 none, 1 read-only, 2 FIFO, 3 RAM |

## Verification
The assertions assume that the FIFO window ends at or below address 256, so that the 8-bit pointer can reach hi-1. The stimulus therefore only ever programs fifo_max up to 32, or to 0x1F. The property windows also assume that no host count write or opposing push or pop lands in the checked cycle, and each property states this in its antecedent. The random mix drives these strobes at moderate rates so that both the guarded cases and the collisions occur. Directed sequences cover the wrap at hi-1, an empty pop, a full push, a threshold crossing and the modulo wrap of the virtual counter.

// File: rtl/ios_fifo_pkg.sv
package ios_fifo_pkg;
    localparam int SEG_SHIFT = 3;
    localparam int IRQ_SIZE  = 0;
    localparam int IRQ_OVF   = 1;
    localparam int IRQ_UNF   = 2;
    localparam int NORAM_SEG = 'h1F;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RO   = 2'd1,
        RGN_FIFO = 2'd2,
        RGN_RAM  = 2'd3
    } region_e;
endpackage

// File: rtl/ios_region_map.sv
module ios_region_map #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] fifo_lo,
    input  logic [ADDR_W-1:0] fifo_hi,
    input  logic [ADDR_W-1:0] ro_lo,
    input  logic              no_ram,
    output logic [1:0]        region
);
    import ios_fifo_pkg::*;

    region_e region_d;

    always_comb begin
        if ((addr >= fifo_lo) && (addr < fifo_hi))
            region_d = RGN_FIFO;
        else if ((addr >= ro_lo) && (addr < fifo_lo))
            region_d = RGN_RO;
        else if (addr >= fifo_hi)
            region_d = no_ram ? RGN_NONE : RGN_RAM;
        else
            region_d = RGN_NONE;
    end

    assign region = region_d;
endmodule

// File: rtl/ios_fifo_state.sv
module ios_fifo_state #(
    parameter int PTR_W  = 8,
    parameter int CNT_W  = 8,
    parameter int VCNT_W = 10,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_vld,
    input  logic              push_vld,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              vinc_we,
    input  logic [VCNT_W-1:0] vinc_value,
    input  logic [CNT_W-1:0]  thr,
    input  logic [ADDR_W-1:0] fifo_lo,
    input  logic [ADDR_W-1:0] fifo_hi,
    input  logic [ADDR_W-1:0] fifo_size,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [VCNT_W-1:0] vcnt_q,
    output logic              evt_size,
    output logic              evt_ovf,
    output logic              evt_unf
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  cnt;
        logic [VCNT_W-1:0] vcnt;
    } fstate_t;

    fstate_t st_d, st_q;
    logic pop_ok_d, push_ok_d;
    logic [ADDR_W-1:0] last_d;
    logic [VCNT_W-1:0] inc_d;

    always_comb begin
        st_d      = st_q;
        pop_ok_d  = pop_vld && (st_q.cnt != '0);
        push_ok_d = push_vld && (ADDR_W'(st_q.cnt) < fifo_size);
        last_d    = fifo_hi - ADDR_W'(1);
        inc_d     = vinc_we ? vinc_value : '0;

        if (ptr_we)
            st_d.ptr = ptr_wdata;
        else if (pop_ok_d)
            st_d.ptr = (ADDR_W'(st_q.ptr) == last_d) ? PTR_W'(fifo_lo)
                                                     : st_q.ptr + PTR_W'(1);

        if (cnt_we)
            st_d.cnt = cnt_wdata;
        else
            st_d.cnt = st_q.cnt + CNT_W'(push_ok_d) - CNT_W'(pop_ok_d);

        st_d.vcnt = st_q.vcnt + inc_d - VCNT_W'(pop_ok_d);

        evt_unf  = pop_vld && (st_q.cnt == '0);
        evt_ovf  = push_vld && !push_ok_d;
        evt_size = (st_q.cnt > thr) && (st_d.cnt <= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q  = st_q.ptr;
    assign cnt_q  = st_q.cnt;
    assign vcnt_q = st_q.vcnt;
endmodule

// File: rtl/ios_irq_bank.sv
module ios_irq_bank #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] en_q,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < W; i++) begin
            // a set or event in the same cycle beats a clear
            bk_d.stat[i] = evt[i] | set[i] | (bk_q.stat[i] & ~clr[i]);
        end
        if (en_we) bk_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign stat_q  = bk_q.stat;
    assign en_q    = bk_q.en;
    assign pending = |(bk_q.stat & bk_q.en);
endmodule

// File: rtl/ios_fifo_tracker.sv
module ios_fifo_tracker #(
    parameter int PTR_W    = 8,
    parameter int CNT_W    = 8,
    parameter int VCNT_W   = 10,
    parameter int NUM_IRQ  = 10,
    parameter int IO_W     = 8,
    parameter int BASE_W   = 5,
    parameter int MAX_W    = 6,
    parameter int RO_W     = 6,
    parameter int RO_RESET = 'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [BASE_W-1:0]  cfg_fifo_base,
    input  logic [MAX_W-1:0]   cfg_fifo_max,
    input  logic [RO_W-1:0]    cfg_ro_base,
    input  logic               thr_we,
    input  logic [CNT_W-1:0]   thr_wdata,
    input  logic               ptr_we,
    input  logic [PTR_W-1:0]   ptr_wdata,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               push_vld,
    input  logic               pop_vld,
    input  logic               vinc_we,
    input  logic [VCNT_W-1:0]  vinc_value,
    input  logic [NUM_IRQ-1:0] ext_evt,
    input  logic [NUM_IRQ-1:0] irq_set,
    input  logic [NUM_IRQ-1:0] irq_clr,
    input  logic               irq_en_we,
    input  logic [NUM_IRQ-1:0] irq_en_wdata,
    input  logic [IO_W-1:0]    io_set,
    input  logic               io_clr_all,
    input  logic               io_en_we,
    input  logic [IO_W-1:0]    io_en_wdata,
    input  logic [ios_fifo_pkg::SEG_SHIFT+((MAX_W > RO_W) ? MAX_W : RO_W)-1:0] ram_addr,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic [VCNT_W-1:0]  vcnt,
    output logic [NUM_IRQ-1:0] irq_status,
    output logic [NUM_IRQ-1:0] irq_enable,
    output logic [IO_W-1:0]    io_irq,
    output logic [IO_W-1:0]    io_irq_en,
    output logic               irq_out,
    output logic [1:0]         ram_region
);
    import ios_fifo_pkg::*;

    localparam int SEG_W  = (MAX_W > RO_W) ? MAX_W : RO_W;
    localparam int ADDR_W = SEG_W + SEG_SHIFT;

    typedef struct packed {
        logic [BASE_W-1:0] fifo_base;
        logic [MAX_W-1:0]  fifo_max;
        logic [RO_W-1:0]   ro_base;
        logic [CNT_W-1:0]  thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.fifo_base = cfg_fifo_base;
            cfg_d.fifo_max  = cfg_fifo_max;
            cfg_d.ro_base   = cfg_ro_base;
        end
        if (thr_we) cfg_d.thr = thr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.ro_base <= RO_W'(RO_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // segment bases scaled to byte addresses
    logic [ADDR_W-1:0] fifo_lo, fifo_hi, ro_lo, fifo_size;
    logic              no_ram;

    assign fifo_lo   = ADDR_W'(cfg_q.fifo_base) << SEG_SHIFT;
    assign fifo_hi   = ADDR_W'(cfg_q.fifo_max)  << SEG_SHIFT;
    assign ro_lo     = ADDR_W'(cfg_q.ro_base)   << SEG_SHIFT;
    assign fifo_size = (fifo_hi > fifo_lo) ? (fifo_hi - fifo_lo) : '0;
    assign no_ram    = (cfg_q.fifo_max == MAX_W'(NORAM_SEG));

    ios_region_map #(.ADDR_W(ADDR_W)) u_region (
        .addr    (ram_addr),
        .fifo_lo (fifo_lo),
        .fifo_hi (fifo_hi),
        .ro_lo   (ro_lo),
        .no_ram  (no_ram),
        .region  (ram_region)
    );

    logic evt_size, evt_ovf, evt_unf;

    ios_fifo_state #(
        .PTR_W (PTR_W), .CNT_W (CNT_W), .VCNT_W (VCNT_W), .ADDR_W (ADDR_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_vld    (pop_vld),
        .push_vld   (push_vld),
        .ptr_we     (ptr_we),
        .ptr_wdata  (ptr_wdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .vinc_we    (vinc_we),
        .vinc_value (vinc_value),
        .thr        (cfg_q.thr),
        .fifo_lo    (fifo_lo),
        .fifo_hi    (fifo_hi),
        .fifo_size  (fifo_size),
        .ptr_q      (rd_ptr),
        .cnt_q      (byte_cnt),
        .vcnt_q     (vcnt),
        .evt_size   (evt_size),
        .evt_ovf    (evt_ovf),
        .evt_unf    (evt_unf)
    );

    logic [NUM_IRQ-1:0] main_evt;
    always_comb begin
        main_evt           = ext_evt;
        main_evt[IRQ_SIZE] = ext_evt[IRQ_SIZE] | evt_size;
        main_evt[IRQ_OVF]  = ext_evt[IRQ_OVF]  | evt_ovf;
        main_evt[IRQ_UNF]  = ext_evt[IRQ_UNF]  | evt_unf;
    end

    logic main_pend, io_pend;

    ios_irq_bank #(.W(NUM_IRQ)) u_main_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (main_evt),
        .set      (irq_set),
        .clr      (irq_clr),
        .en_we    (irq_en_we),
        .en_wdata (irq_en_wdata),
        .stat_q   (irq_status),
        .en_q     (irq_enable),
        .pending  (main_pend)
    );

    ios_irq_bank #(.W(IO_W)) u_io_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      ('0),
        .set      (io_set),
        .clr      ({IO_W{io_clr_all}}),
        .en_we    (io_en_we),
        .en_wdata (io_en_wdata),
        .stat_q   (io_irq),
        .en_q     (io_irq_en),
        .pending  (io_pend)
    );

    assign irq_out = main_pend | io_pend;
endmodule

// File: rtl/ios_fifo_tracker_chk.sv
module ios_fifo_tracker_chk #(
    parameter int PTR_W   = 8,
    parameter int CNT_W   = 8,
    parameter int VCNT_W  = 10,
    parameter int NUM_IRQ = 10,
    parameter int IO_W    = 8,
    parameter int MAX_W   = 6,
    parameter int ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pop_vld,
    input logic               push_vld,
    input logic               ptr_we,
    input logic               cnt_we,
    input logic               vinc_we,
    input logic [VCNT_W-1:0]  vinc_value,
    input logic [NUM_IRQ-1:0] ext_evt,
    input logic [NUM_IRQ-1:0] irq_set,
    input logic [NUM_IRQ-1:0] irq_clr,
    input logic [IO_W-1:0]    io_set,
    input logic               io_clr_all,
    input logic [ADDR_W-1:0]  ram_addr,
    input logic [PTR_W-1:0]   rd_ptr,
    input logic [CNT_W-1:0]   byte_cnt,
    input logic [VCNT_W-1:0]  vcnt,
    input logic [NUM_IRQ-1:0] irq_status,
    input logic [NUM_IRQ-1:0] irq_enable,
    input logic [IO_W-1:0]    io_irq,
    input logic [IO_W-1:0]    io_irq_en,
    input logic               irq_out,
    input logic [1:0]         ram_region,
    input logic [ADDR_W-1:0]  fifo_lo,
    input logic [ADDR_W-1:0]  fifo_hi,
    input logic [ADDR_W-1:0]  fifo_size,
    input logic [MAX_W-1:0]   fifo_max
);
    import ios_fifo_pkg::*;

    assert_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_max == MAX_W'(NORAM_SEG) && ram_addr >= fifo_hi) |-> (ram_region == RGN_NONE));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_vld && !ptr_we && byte_cnt != '0 && ADDR_W'(rd_ptr) == fifo_hi - ADDR_W'(1))
        |=> (rd_ptr == $past(PTR_W'(fifo_lo))));

    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_vld && !push_vld && !cnt_we && byte_cnt == '0)
        |=> (irq_status[IRQ_UNF] && byte_cnt == '0));

    assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && !pop_vld && !cnt_we && ADDR_W'(byte_cnt) >= fifo_size)
        |=> (irq_status[IRQ_OVF] && $stable(byte_cnt)));

    assert_vinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vinc_we && !pop_vld) |=> (vcnt == VCNT_W'($past(vcnt) + $past(vinc_value))));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&irq_clr) && irq_set == '0 && ext_evt == '0 && !pop_vld && !push_vld && !cnt_we)
        |=> (irq_status == '0));

    assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enable == '0 && io_irq_en == '0) |-> !irq_out);

    assert_io_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_clr_all && io_set == '0) |=> (io_irq == '0));
endmodule

bind ios_fifo_tracker ios_fifo_tracker_chk #(
    .PTR_W (PTR_W), .CNT_W (CNT_W), .VCNT_W (VCNT_W), .NUM_IRQ (NUM_IRQ),
    .IO_W (IO_W), .MAX_W (MAX_W), .ADDR_W (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_vld    (pop_vld),
    .push_vld   (push_vld),
    .ptr_we     (ptr_we),
    .cnt_we     (cnt_we),
    .vinc_we    (vinc_we),
    .vinc_value (vinc_value),
    .ext_evt    (ext_evt),
    .irq_set    (irq_set),
    .irq_clr    (irq_clr),
    .io_set     (io_set),
    .io_clr_all (io_clr_all),
    .ram_addr   (ram_addr),
    .rd_ptr     (rd_ptr),
    .byte_cnt   (byte_cnt),
    .vcnt       (vcnt),
    .irq_status (irq_status),
    .irq_enable (irq_enable),
    .io_irq     (io_irq),
    .io_irq_en  (io_irq_en),
    .irq_out    (irq_out),
    .ram_region (ram_region),
    .fifo_lo    (fifo_lo),
    .fifo_hi    (fifo_hi),
    .fifo_size  (fifo_size),
    .fifo_max   (cfg_q.fifo_max)
);

// File: tb/test_ios_fifo_tracker.sv
`timescale 1ns/1ps
module test_ios_fifo_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       cfg_we = 0;
    logic [4:0] cfg_fifo_base = 0;
    logic [5:0] cfg_fifo_max = 0;
    logic [5:0] cfg_ro_base = 0;
    logic       thr_we = 0;
    logic [7:0] thr_wdata = 0;
    logic       ptr_we = 0;
    logic [7:0] ptr_wdata = 0;
    logic       cnt_we = 0;
    logic [7:0] cnt_wdata = 0;
    logic       push_vld = 0, pop_vld = 0, vinc_we = 0;
    logic [9:0] vinc_value = 0;
    logic [9:0] ext_evt = 0, irq_set = 0, irq_clr = 0;
    logic       irq_en_we = 0;
    logic [9:0] irq_en_wdata = 0;
    logic [7:0] io_set = 0;
    logic       io_clr_all = 0, io_en_we = 0;
    logic [7:0] io_en_wdata = 0;
    logic [8:0] ram_addr = 0;

    logic [7:0] rd_ptr, byte_cnt, io_irq, io_irq_en;
    logic [9:0] vcnt, irq_status, irq_enable;
    logic       irq_out;
    logic [1:0] ram_region;

    ios_fifo_tracker i_ios_fifo_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_base(cfg_fifo_base),
        .cfg_fifo_max(cfg_fifo_max), .cfg_ro_base(cfg_ro_base), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .push_vld(push_vld), .pop_vld(pop_vld), .vinc_we(vinc_we),
        .vinc_value(vinc_value), .ext_evt(ext_evt), .irq_set(irq_set), .irq_clr(irq_clr),
        .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata), .io_set(io_set),
        .io_clr_all(io_clr_all), .io_en_we(io_en_we), .io_en_wdata(io_en_wdata),
        .ram_addr(ram_addr), .rd_ptr(rd_ptr), .byte_cnt(byte_cnt), .vcnt(vcnt),
        .irq_status(irq_status), .irq_enable(irq_enable), .io_irq(io_irq),
        .io_irq_en(io_irq_en), .irq_out(irq_out), .ram_region(ram_region)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int m_base = 0, m_max = 0, m_ro = 'h20, m_thr = 0;
    int m_ptr = 0, m_cnt = 0, m_vcnt = 0;
    logic [9:0] m_stat = 0, m_en = 0;
    logic [7:0] m_io = 0, m_ioen = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_region(input int a);
        int lo, hi, ro;
        lo = m_base * 8; hi = m_max * 8; ro = m_ro * 8;
        if (a >= lo && a < hi) return 2;
        if (a >= ro && a < lo) return 1;
        if (a >= hi) return (m_max == 'h1F) ? 0 : 3;
        return 0;
    endfunction

    task automatic clear_strobes();
        cfg_we = 0; thr_we = 0; ptr_we = 0; cnt_we = 0; push_vld = 0; pop_vld = 0;
        vinc_we = 0; ext_evt = 0; irq_set = 0; irq_clr = 0; irq_en_we = 0;
        io_set = 0; io_clr_all = 0; io_en_we = 0;
    endtask

    // advance one clock, update the model and compare every output
    task automatic step();
        int lo, hi, sz, n_ptr, n_cnt, n_vcnt;
        bit pop_ok, push_ok, unf, ovf, sz_ev;
        logic [9:0] ev;
        lo = m_base * 8; hi = m_max * 8;
        sz = (hi > lo) ? hi - lo : 0;
        pop_ok  = pop_vld && m_cnt != 0;
        push_ok = push_vld && m_cnt < sz;
        unf = pop_vld && m_cnt == 0;
        ovf = push_vld && !push_ok;
        n_ptr = ptr_we ? int'(ptr_wdata)
              : pop_ok ? ((m_ptr == hi - 1) ? (lo & 255) : ((m_ptr + 1) & 255)) : m_ptr;
        n_cnt = cnt_we ? int'(cnt_wdata) : ((m_cnt + int'(push_ok) - int'(pop_ok)) & 255);
        n_vcnt = (m_vcnt + (vinc_we ? int'(vinc_value) : 0) - int'(pop_ok)) & 1023;
        sz_ev = (m_cnt > m_thr) && (n_cnt <= m_thr);
        ev = ext_evt;
        ev[0] = ev[0] | sz_ev;
        ev[1] = ev[1] | ovf;
        ev[2] = ev[2] | unf;
        @(posedge clk);
        @(negedge clk);
        m_stat = ev | irq_set | (m_stat & ~irq_clr);
        if (irq_en_we) m_en = irq_en_wdata;
        m_io = io_set | (io_clr_all ? 8'h00 : m_io);
        if (io_en_we) m_ioen = io_en_wdata;
        if (cfg_we) begin m_base = cfg_fifo_base; m_max = cfg_fifo_max; m_ro = cfg_ro_base; end
        if (thr_we) m_thr = thr_wdata;
        m_ptr = n_ptr; m_cnt = n_cnt; m_vcnt = n_vcnt;
        chk("R4 R12 pointer", rd_ptr, m_ptr);
        chk("R6 R12 count", byte_cnt, m_cnt);
        chk("R8 virtual counter", vcnt, m_vcnt);
        chk("R5 R6 R7 R9 status", irq_status, m_stat);
        chk("R9 enable", irq_enable, m_en);
        chk("R11 io field", {io_irq_en, io_irq}, {m_ioen, m_io});
        chk("R10 irq_out", irq_out, int'(|(m_stat & m_en) || |(m_io & m_ioen)));
        chk("R2 R3 region", ram_region, m_region(ram_addr));
        clear_strobes();
    endtask

    task automatic set_cfg(input int b, input int mx, input int ro);
        cfg_we = 1; cfg_fifo_base = 5'(b); cfg_fifo_max = 6'(mx); cfg_ro_base = 6'(ro);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pointer", rd_ptr, 0);
        chk("R1 count", byte_cnt, 0);
        chk("R1 vcnt", vcnt, 0);
        chk("R1 status", irq_status, 0);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 io", io_irq, 0);
        rst_n = 1;
        @(negedge clk);
        ram_addr = 9'd300;
        step();   // R1/R2: ro base 0x20 with empty FIFO, address 300 is RAM

        // R3: no RAM region when limit is 0x1F
        set_cfg(4, 'h1F, 2);
        ram_addr = 9'd300; step();
        ram_addr = 9'd40;  step();
        ram_addr = 9'd20;  step();
        ram_addr = 9'd5;   step();

        // R4 and R12: wrap from hi-1 back to lo
        set_cfg(2, 3, 1);
        ptr_we = 1; ptr_wdata = 8'd22; cnt_we = 1; cnt_wdata = 8'd3; step();
        pop_vld = 1; step();
        pop_vld = 1; step();
        pop_vld = 1; step();
        // R5: pop on an empty FIFO
        pop_vld = 1; step();
        // R6: fill to 8 then overflow
        for (int i = 0; i < 9; i++) begin push_vld = 1; step(); end
        // R9: clear all
        irq_clr = '1; step();
        // R7: threshold crossing
        thr_we = 1; thr_wdata = 8'd5; step();
        cnt_we = 1; cnt_wdata = 8'd6; step();
        pop_vld = 1; step();
        pop_vld = 1; step();
        // R8: modulo wrap and simultaneous increment and pop
        vinc_we = 1; vinc_value = 10'd1000; step();
        vinc_we = 1; vinc_value = 10'd40; step();
        vinc_we = 1; vinc_value = 10'd10; pop_vld = 1; step();
        // R9: set wins over clear; R10 masking
        irq_set = 10'h200; irq_clr = 10'h200; step();
        irq_en_we = 1; irq_en_wdata = 10'h200; step();
        irq_clr = 10'h200; step();
        // R11: io field set and clear-all
        io_set = 8'hA5; io_en_we = 1; io_en_wdata = 8'h01; step();
        io_clr_all = 1; io_set = 8'h10; step();
        io_clr_all = 1; step();

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 99) < 2) begin
                int b;
                b = $urandom_range(0, 8);
                cfg_we = 1; cfg_fifo_base = 5'(b);
                cfg_fifo_max = ($urandom_range(0, 9) == 0) ? 6'h1F : 6'(b + $urandom_range(0, 6));
                cfg_ro_base = 6'($urandom_range(0, 10));
            end
            if ($urandom_range(0, 99) < 3) begin thr_we = 1; thr_wdata = 8'($urandom_range(0, 20)); end
            if ($urandom_range(0, 99) < 3) begin ptr_we = 1; ptr_wdata = 8'($urandom); end
            if ($urandom_range(0, 99) < 3) begin cnt_we = 1; cnt_wdata = 8'($urandom_range(0, 40)); end
            push_vld = ($urandom_range(0, 99) < 45);
            pop_vld  = ($urandom_range(0, 99) < 45);
            if ($urandom_range(0, 99) < 10) begin vinc_we = 1; vinc_value = 10'($urandom); end
            if ($urandom_range(0, 99) < 10) ext_evt = 10'(1 << $urandom_range(0, 9));
            if ($urandom_range(0, 99) < 5)  irq_set = 10'($urandom);
            if ($urandom_range(0, 99) < 15) irq_clr = 10'($urandom);
            if ($urandom_range(0, 99) < 5) begin irq_en_we = 1; irq_en_wdata = 10'($urandom); end
            if ($urandom_range(0, 99) < 5)  io_set = 8'($urandom);
            if ($urandom_range(0, 99) < 4)  io_clr_all = 1;
            if ($urandom_range(0, 99) < 4) begin io_en_we = 1; io_en_wdata = 8'($urandom); end
            ram_addr = 9'($urandom);
            step();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule